// File: doc/BRIEF.md
# Block Register Transfer Address Sequencer

This block turns one multi-register load or store into a stream of single transfers. When the start pulse is sampled in the idle state, it latches a 16-bit register bitmap and a 32-bit base address. It then issues one (register index, memory address) pair for each set bit in the bitmap. Pairs come out in ascending register order, and each is handed off through a valid/ready handshake. The memory range is contiguous, uses 4-byte steps, and always gives the lowest-numbered register the lowest address.

Two control bits select one of four address orders. The direction bit picks increment or decrement. The pre-step bit says whether the step is applied before the first access or after it. The block computes the base writeback value, base plus or minus four times the number of listed registers, when the operation starts. That value is reported with the final transfer. A done pulse marks the end of each operation.

The control is a three-state machine:
- IDLE waits for start.
- IDLE→EMIT happens on start with a non-empty list.
- IDLE→DONE happens on start with an empty list.
- EMIT stays in EMIT on every handshake except the last, and on every stalled cycle.
- EMIT→DONE happens on the handshake of the final transfer.
- DONE→IDLE always happens after one cycle, and done is raised during that cycle.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, xfer_valid_o and done_o are low.
- R2: Each set bit i of reg_list_i produces exactly one transfer with xfer_reg_o = i, and the transfers come out in strictly ascending index order.
- R3: Successive transfers of one operation carry addresses that rise by exactly 4, so the lowest register gets the lowest address.
- R4: The first transfer's address depends on dir_down_i (0 = increment, 1 = decrement) and pre_step_i (1 = step before the access), with N the number of set bits. Increment-after gives base. Increment-before gives base+4. Decrement-after gives base−4N+4. Decrement-before gives base−4N.
- R5: xfer_last_o is high on the final transfer of an operation and low on every other transfer.
- R6: While xfer_valid_o is high and xfer_ready_i is low, the register index, address and last flag hold their values. A transfer completes only on a cycle where valid and ready are both high.
- R7: wb_base_o equals base+4N for increment and base−4N for decrement, and it is correct on the final transfer. wb_valid_o is high only on the final transfer, and only when wb_en_i was high at start.
- R8: done_o is high for exactly one cycle, the cycle right after the final handshake.
- R9: An empty list produces no transfer. done_o is high on the cycle after start is sampled, and wb_base_o then equals the unchanged base.
- R10: A start pulse that arrives while an operation is in progress is ignored, and the running sequence continues unaltered.
- R11: Address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Operation start pulse; sampled only in IDLE |
| reg_list_i | input | 16 | Register bitmap; bit i selects register i |
| base_i | input | 32 | Base address |
| dir_down_i | input | 1 | 0 = increment, 1 = decrement |
| pre_step_i | input | 1 | 1 = step before the first access |
| wb_en_i | input | 1 | Request base writeback |
| xfer_valid_o | output | 1 | Transfer pair valid |
| xfer_ready_i | input | 1 | Consumer accepts the transfer |
| xfer_reg_o | output | 4 | Register index of the transfer |
| xfer_addr_o | output | 32 | Memory address of the transfer |
| xfer_last_o | output | 1 | Final transfer of the operation |
| wb_valid_o | output | 1 | Writeback value valid (final transfer, writeback enabled) |
| wb_base_o | output | 32 | Updated base value |
| done_o | output | 1 | One-cycle end-of-operation pulse |

## Verification
The properties let xfer_ready_i change freely on any cycle. They also assume that the bitmap and base are only meaningful on the cycle start_i is sampled. They make no assumption about start_i while an operation runs, because the block must ignore it there. The stimulus changes ready only just after a clock edge, either held high or driven from a pseudo-random sequence, and it pulses start for a single cycle. It then waits for done before launching the next operation. The one exception is a deliberate mid-operation start, which probes the rule that such a pulse is ignored.

// File: rtl/bxs_pkg.sv
package bxs_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EMIT = 2'd1,
        S_DONE = 2'd2
    } bxs_state_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } bxs_dir_e;

endpackage

// File: rtl/bxs_popcnt.sv
module bxs_popcnt #(
    parameter int W = 16,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  mask_i,
    output logic [CW-1:0] count_o
);

    // Ripple of partial sums, one stage per bitmap bit.
    logic [CW-1:0] partial [W+1];

    assign partial[0] = '0;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_sum
            assign partial[g+1] = partial[g] + CW'(mask_i[g]);
        end
    endgenerate

    assign count_o = partial[W];

endmodule

// File: rtl/bxs_lowbit.sv
module bxs_lowbit #(
    parameter int W = 16,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  mask_i,
    output logic [IW-1:0] index_o
);

    // Lowest set bit wins: scan downward so the smallest index is written last.
    always_comb begin
        index_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                index_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/bxs_span.sv
module bxs_span #(
    parameter int AW   = 32,
    parameter int CW   = 5,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] count_i,
    input  logic          dir_down_i,
    input  logic          pre_step_i,
    output logic [AW-1:0] first_addr_o,
    output logic [AW-1:0] new_base_o
);

    import bxs_pkg::*;

    localparam logic [AW-1:0] STEP_A = AW'(STEP);

    logic [AW-1:0] span;
    logic [AW-1:0] low_down;

    assign span     = AW'(count_i) * STEP_A;
    assign low_down = base_i - span;

    always_comb begin
        if (bxs_dir_e'(dir_down_i) == DIR_DOWN) begin
            first_addr_o = pre_step_i ? low_down : (low_down + STEP_A);
            new_base_o   = low_down;
        end else begin
            first_addr_o = pre_step_i ? (base_i + STEP_A) : base_i;
            new_base_o   = base_i + span;
        end
    end

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int STEP = 4,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int CW  = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [NREG-1:0] reg_list_i,
    input  logic [AW-1:0]   base_i,
    input  logic            dir_down_i,
    input  logic            pre_step_i,
    input  logic            wb_en_i,
    output logic            xfer_valid_o,
    input  logic            xfer_ready_i,
    output logic [IW-1:0]   xfer_reg_o,
    output logic [AW-1:0]   xfer_addr_o,
    output logic            xfer_last_o,
    output logic            wb_valid_o,
    output logic [AW-1:0]   wb_base_o,
    output logic            done_o
);

    import bxs_pkg::*;

    localparam logic [AW-1:0] STEP_A = AW'(STEP);

    bxs_state_e      state_q, state_d;
    logic [NREG-1:0] mask_q;
    logic [AW-1:0]   addr_q;
    logic [AW-1:0]   wb_q;
    logic            wben_q;

    logic [CW-1:0]   list_cnt;
    logic [AW-1:0]   first_addr;
    logic [AW-1:0]   new_base;
    logic [IW-1:0]   cur_idx;
    logic            single_left;
    logic            fire;
    logic            list_empty;

    // Count of requested registers, taken straight from the input bitmap.
    bxs_popcnt #(.W(NREG)) u_cnt (
        .mask_i  (reg_list_i),
        .count_o (list_cnt)
    );

    // First address and writeback value for the selected order.
    bxs_span #(.AW(AW), .CW(CW), .STEP(STEP)) u_span (
        .base_i       (base_i),
        .count_i      (list_cnt),
        .dir_down_i   (dir_down_i),
        .pre_step_i   (pre_step_i),
        .first_addr_o (first_addr),
        .new_base_o   (new_base)
    );

    // Index of the next register still pending.
    bxs_lowbit #(.W(NREG)) u_pick (
        .mask_i  (mask_q),
        .index_o (cur_idx)
    );

    assign list_empty  = (reg_list_i == '0);
    assign single_left = ((mask_q & (mask_q - 1'b1)) == '0);
    assign fire        = (state_q == S_EMIT) && xfer_ready_i;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    state_d = list_empty ? S_DONE : S_EMIT;
                end
            end
            S_EMIT: begin
                if (fire && single_left) begin
                    state_d = S_DONE;
                end
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // Operation context: pending bitmap, current address, writeback value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            addr_q <= '0;
            wb_q   <= '0;
            wben_q <= 1'b0;
        end else begin
            if (state_q == S_IDLE && start_i) begin
                mask_q <= reg_list_i;
                addr_q <= first_addr;
                wb_q   <= new_base;
                wben_q <= wb_en_i;
            end else if (fire) begin
                mask_q <= mask_q & (mask_q - 1'b1);
                addr_q <= addr_q + STEP_A;
            end
        end
    end

    // Outputs.
    always_comb begin
        xfer_valid_o = (state_q == S_EMIT);
        xfer_reg_o   = cur_idx;
        xfer_addr_o  = addr_q;
        xfer_last_o  = xfer_valid_o && single_left;
        wb_valid_o   = xfer_last_o && wben_q;
        wb_base_o    = wb_q;
        done_o       = (state_q == S_DONE);
    end

endmodule

// File: rtl/bxs_chk.sv
module bxs_chk #(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int STEP = 4,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic [NREG-1:0]      reg_list_i,
    input bxs_pkg::bxs_state_e  state_i,
    input logic                 xfer_valid_o,
    input logic                 xfer_ready_i,
    input logic [IW-1:0]        xfer_reg_o,
    input logic [AW-1:0]        xfer_addr_o,
    input logic                 xfer_last_o,
    input logic                 wb_valid_o,
    input logic                 done_o
);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid_o && !xfer_ready_i |=>
            xfer_valid_o && $stable(xfer_reg_o) && $stable(xfer_addr_o) && $stable(xfer_last_o));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid_o && xfer_ready_i && !xfer_last_o |=>
            xfer_valid_o && (xfer_addr_o == $past(xfer_addr_o) + AW'(STEP)));

    p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid_o && xfer_ready_i && !xfer_last_o |=> xfer_reg_o > $past(xfer_reg_o));

    p_wb_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> xfer_valid_o && xfer_last_o);

    p_done_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid_o && xfer_ready_i && xfer_last_o |=> done_o && !xfer_valid_o);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && (state_i == bxs_pkg::S_IDLE) && (reg_list_i == '0) |=> done_o && !xfer_valid_o);

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && xfer_valid_o && !(xfer_ready_i && xfer_last_o) |=> xfer_valid_o && !done_o);

endmodule

bind blk_xfer_seq bxs_chk #(.NREG(NREG), .AW(AW), .STEP(STEP)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .reg_list_i   (reg_list_i),
    .state_i      (state_q),
    .xfer_valid_o (xfer_valid_o),
    .xfer_ready_i (xfer_ready_i),
    .xfer_reg_o   (xfer_reg_o),
    .xfer_addr_o  (xfer_addr_o),
    .xfer_last_o  (xfer_last_o),
    .wb_valid_o   (wb_valid_o),
    .done_o       (done_o)
);

// File: tb/blk_xfer_seq_tb_top.sv
module blk_xfer_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] reg_list_i = '0;
    logic [31:0] base_i = '0;
    logic        dir_down_i = 1'b0;
    logic        pre_step_i = 1'b0;
    logic        wb_en_i = 1'b0;
    logic        xfer_ready_i = 1'b1;
    logic        xfer_valid_o;
    logic [3:0]  xfer_reg_o;
    logic [31:0] xfer_addr_o;
    logic        xfer_last_o;
    logic        wb_valid_o;
    logic [31:0] wb_base_o;
    logic        done_o;

    always #5 clk = ~clk;

    blk_xfer_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .reg_list_i   (reg_list_i),
        .base_i       (base_i),
        .dir_down_i   (dir_down_i),
        .pre_step_i   (pre_step_i),
        .wb_en_i      (wb_en_i),
        .xfer_valid_o (xfer_valid_o),
        .xfer_ready_i (xfer_ready_i),
        .xfer_reg_o   (xfer_reg_o),
        .xfer_addr_o  (xfer_addr_o),
        .xfer_last_o  (xfer_last_o),
        .wb_valid_o   (wb_valid_o),
        .wb_base_o    (wb_base_o),
        .done_o       (done_o)
    );

    typedef struct {
        logic [3:0]  rg;
        logic [31:0] ad;
        logic        lst;
        logic        first;
        logic        wv;
        logic [31:0] wb;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   done_cnt = 0;
    bit   pend_done = 0;
    bit   rand_rdy = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Ready driver: changes only just after a rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            xfer_ready_i = rand_rdy ? lfsr[0] : 1'b1;
        end
    end

    // Monitor: compares the presented transfer with the scoreboard head.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (pend_done) begin
                    check(done_o == 1'b1, "R8 done after end", 32'(done_o), 32'd1);
                    pend_done = 0;
                end
                if (done_o) done_cnt++;
                if (xfer_valid_o) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2 unexpected transfer", {28'd0, xfer_reg_o}, 32'hFFFF_FFFF);
                    end else if (!xfer_ready_i) begin
                        check(xfer_reg_o == exp_q[0].rg && xfer_addr_o == exp_q[0].ad,
                              "R6 stalled item held", xfer_addr_o, exp_q[0].ad);
                    end else begin
                        check(xfer_reg_o == exp_q[0].rg, "R2 register index", {28'd0, xfer_reg_o}, {28'd0, exp_q[0].rg});
                        if (exp_q[0].first)
                            check(xfer_addr_o == exp_q[0].ad, "R4 first address", xfer_addr_o, exp_q[0].ad);
                        else
                            check(xfer_addr_o == exp_q[0].ad, "R3 next address", xfer_addr_o, exp_q[0].ad);
                        check(xfer_last_o == exp_q[0].lst, "R5 last flag", 32'(xfer_last_o), 32'(exp_q[0].lst));
                        check(wb_valid_o == exp_q[0].wv, "R7 writeback valid", 32'(wb_valid_o), 32'(exp_q[0].wv));
                        if (exp_q[0].lst) begin
                            check(wb_base_o == exp_q[0].wb, "R7 writeback value", wb_base_o, exp_q[0].wb);
                            pend_done = 1;
                        end
                        void'(exp_q.pop_front());
                    end
                end
            end
        end
    end

    task automatic run_op(input logic [15:0] lst, input logic [31:0] base, input bit dn,
                          input bit pre, input bit wb, input bit poke);
        int n = 0;
        int k = 0;
        int d0;
        logic [31:0] lo;
        logic [31:0] nb;
        for (int i = 0; i < 16; i++) if (lst[i]) n++;
        if (dn) begin
            nb = base - 32'(4 * n);
            lo = pre ? nb : nb + 32'd4;
        end else begin
            nb = base + 32'(4 * n);
            lo = pre ? base + 32'd4 : base;
        end
        for (int i = 0; i < 16; i++) begin
            if (lst[i]) begin
                exp_t e;
                e.rg = 4'(i);
                e.ad = lo + 32'(4 * k);
                e.first = (k == 0);
                e.lst = (k == n - 1);
                e.wv = e.lst && wb;
                e.wb = nb;
                exp_q.push_back(e);
                k++;
            end
        end
        d0 = done_cnt;
        @(posedge clk);
        #1;
        reg_list_i = lst; base_i = base; dir_down_i = dn; pre_step_i = pre; wb_en_i = wb;
        start_i = 1'b1;
        @(posedge clk);
        #1;
        start_i = 1'b0;
        if (n == 0) begin
            pend_done = 1;
            @(negedge clk);
            // R9: empty list gives no transfer and an unchanged base
            check(xfer_valid_o == 1'b0, "R9 no transfer", 32'(xfer_valid_o), 32'd0);
            check(wb_base_o == base, "R9 base unchanged", wb_base_o, base);
        end
        if (poke) begin
            // R10: second start mid-operation must be ignored
            @(posedge clk);
            #1;
            reg_list_i = 16'h0001; base_i = 32'h0BAD_0000; dir_down_i = ~dn;
            start_i = 1'b1;
            @(posedge clk);
            #1;
            start_i = 1'b0;
        end
        while (done_cnt == d0) @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R2 transfer count", 32'(exp_q.size()), 32'd0);
        check(done_o == 1'b0, "R8 done one cycle", 32'(done_o), 32'd0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(xfer_valid_o == 1'b0, "R1 reset valid", 32'(xfer_valid_o), 32'd0);
        check(done_o == 1'b0, "R1 reset done", 32'(done_o), 32'd0);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        run_op(16'h0001, 32'h0000_1000, 0, 0, 1, 0);
        run_op(16'h8421, 32'h0000_2000, 0, 0, 0, 0);
        run_op(16'h00F0, 32'h0000_3000, 0, 1, 1, 0);
        run_op(16'h0F0F, 32'h0000_4000, 1, 0, 1, 0);
        rand_rdy = 1;
        run_op(16'hFFFF, 32'h0000_5000, 1, 1, 1, 0);
        // R11: wrap below zero and above the top of the range
        run_op(16'h8001, 32'h0000_0004, 1, 1, 1, 0);
        run_op(16'h0003, 32'hFFFF_FFF8, 0, 1, 1, 0);
        run_op(16'h0000, 32'h0000_7000, 1, 0, 1, 0);
        run_op(16'hFFF0, 32'h0000_8000, 0, 1, 1, 1);
        run_op(16'hA5A5, 32'h0000_9000, 1, 0, 0, 0);
        rand_rdy = 0;
        run_op(16'h0000, 32'h0000_A000, 0, 1, 0, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule